// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block runs scan tests on one multiplexed-D scan chain that is wrapped around a combinational block under test. It drives the chain's shift-enable and serial input. It drives the primary inputs of the block under test. It reads the serial chain output and the primary outputs and grades them against stored expectations. A small pattern memory is loaded through parallel write ports. Each entry holds a chain stimulus, a primary-input vector, an expected chain response, a don't-care mask for that response and an expected primary-output vector.

A session starts with a pulse on `start`, which carries a mode and a pattern count. Four modes are provided:

- Stuck-at with the unload of each response overlapped on the load of the next stimulus.
- Stuck-at with separate load, capture and unload phases.
- Launch-on-capture transition test, using two back-to-back functional clocks.
- Launch-on-shift transition test, where the final shift and the capture that follows are fast.

The clocks themselves are not generated here. Each cycle that must run at the fast rate is flagged on `at_speed`. A sticky `fail` output collects every mismatch, and `done` pulses once when the session ends.

Top module: `scan_test_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `scan_en` and `at_speed` are all low.
- R2: `start` is taken only while idle and with a nonzero `num_pat`. A count of zero, or a `start` seen while busy, has no effect. A count above the memory depth runs the whole memory.
- R3: The chain shifts from `scan_in` toward `scan_out`, so `scan_out` is the last chain position. While loading, stimulus bit CHAIN_LEN-1 is sent first and bit 0 last, so that before the capture chain position i holds stimulus bit i. Every session begins with a shift cycle.
- R4: Mode 0 (overlapped stuck-at) shifts CHAIN_LEN cycles, then for each pattern gives one capture cycle (`scan_en` low) followed by CHAIN_LEN shift cycles. From the second pattern on, those shifts load the next stimulus while unloading the previous response. Busy time is P*(CHAIN_LEN+1)+CHAIN_LEN cycles, with `at_speed` never set.
- R5: Mode 1 (serial stuck-at) gives each pattern a load, one capture and a separate unload, for P*(2*CHAIN_LEN+1) busy cycles.
- R6: Mode 2 (launch-on-capture) loads with CHAIN_LEN slow shifts, then gives two consecutive capture cycles, both flagged at speed. Busy time is P*(CHAIN_LEN+2)+CHAIN_LEN cycles.
- R7: Mode 3 (launch-on-shift) makes CHAIN_LEN-1 slow shifts per load. The final shift and the single capture right after it are flagged at speed. Busy time is P*(CHAIN_LEN+1)+CHAIN_LEN cycles.
- R8: During a pattern's load and its capture cycle(s), `pi_out` carries that pattern's primary-input vector.
- R9: Response bit i is compared with expected bit i in the unload cycle where it appears on `scan_out`. The first bit compared is bit CHAIN_LEN-1. Any mismatch sets `fail`, which stays set until the next accepted `start`.
- R10: An expected chain bit whose mask bit is 1 is a don't-care and never sets `fail`.
- R11: In the last capture cycle of each pattern, `po_in` is compared with the stored expected primary-output vector, and any difference sets `fail`.
- R12: `done` is a one-cycle pulse in the cycle after the final unload shift. `busy` falls in that same cycle.
- R13: A write with `pat_we` high stores all fields of one entry at `pat_addr`, and later sessions use that content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | AW | Pattern entry to write |
| pat_stim | input | CHAIN_LEN | Chain stimulus |
| pat_pi | input | PI_W | Primary-input vector |
| pat_exp | input | CHAIN_LEN | Expected chain response |
| pat_mask | input | CHAIN_LEN | Don't-care mask for the response, 1 = ignore |
| pat_exp_po | input | PO_W | Expected primary outputs |
| start | input | 1 | Session start pulse |
| mode | input | 2 | 0 overlapped stuck-at, 1 serial stuck-at, 2 launch-on-capture, 3 launch-on-shift |
| num_pat | input | IW | Number of patterns to apply |
| scan_en | output | 1 | High = shift, low = functional capture |
| scan_in | output | 1 | Serial data into the chain |
| scan_out | input | 1 | Serial data from the last chain position |
| pi_out | output | PI_W | Primary inputs of the block under test |
| po_in | input | PO_W | Primary outputs of the block under test |
| at_speed | output | 1 | Marks a cycle that must run at the fast clock |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench wraps the sequencer around a model of a 6-bit chain and a mixing combinational function. It sweeps every mode against every pattern count from 1 to 4, so the cycle totals, the capture and at-speed counts, and the single-versus-double capture separate the four sequences. Some expected bits are inverted under their mask bits, so a mask that is ignored shows up as a false failure. Single flipped expected bits, one in the chain response and one in the primary outputs, show that real mismatches are caught. Further cases cover a zero count, a count above the depth and a restart attempt during a session, which probe the start rules. Chain contents checked at each first capture reveal the bit order.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SA_OVL = 2'd0,
        MODE_SA_SER = 2'd1,
        MODE_LOC    = 2'd2,
        MODE_LOS    = 2'd3
    } test_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LAUNCH,
        ST_CAPT
    } seq_state_e;

    // Per-cycle control word produced by the sequencer FSM
    typedef struct packed {
        logic shift;      // scan enable
        logic load;       // a stimulus is being shifted in
        logic unload;     // a response is being shifted out
        logic final_cap;  // last capture cycle of a pattern
        logic at_speed;   // cycle needs the fast clock
    } step_t;

    function automatic logic is_transition(test_mode_e m);
        return (m == MODE_LOC) || (m == MODE_LOS);
    endfunction

endpackage

// File: rtl/scan_pat_mem.sv
module scan_pat_mem #(
    parameter int CHAIN_LEN = 6,
    parameter int PI_W      = 5,
    parameter int PO_W      = 3,
    parameter int DEPTH     = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [CHAIN_LEN-1:0] w_stim,
    input  logic [PI_W-1:0]      w_pi,
    input  logic [CHAIN_LEN-1:0] w_exp,
    input  logic [CHAIN_LEN-1:0] w_mask,
    input  logic [PO_W-1:0]      w_exp_po,
    // port for the pattern being loaded / captured
    input  logic [AW-1:0]        ld_addr,
    output logic [CHAIN_LEN-1:0] ld_stim,
    output logic [PI_W-1:0]      ld_pi,
    output logic [PO_W-1:0]      ld_exp_po,
    // port for the response being unloaded
    input  logic [AW-1:0]        ul_addr,
    output logic [CHAIN_LEN-1:0] ul_exp,
    output logic [CHAIN_LEN-1:0] ul_mask
);

    logic [CHAIN_LEN-1:0] stim_q [DEPTH];
    logic [PI_W-1:0]      pi_q   [DEPTH];
    logic [CHAIN_LEN-1:0] exp_q  [DEPTH];
    logic [CHAIN_LEN-1:0] mask_q [DEPTH];
    logic [PO_W-1:0]      po_q   [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            stim_q[waddr] <= w_stim;
            pi_q[waddr]   <= w_pi;
            exp_q[waddr]  <= w_exp;
            mask_q[waddr] <= w_mask;
            po_q[waddr]   <= w_exp_po;
        end
    end

    assign ld_stim   = stim_q[ld_addr];
    assign ld_pi     = pi_q[ld_addr];
    assign ld_exp_po = po_q[ld_addr];
    assign ul_exp    = exp_q[ul_addr];
    assign ul_mask   = mask_q[ul_addr];

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 6,
    parameter int DEPTH     = 4,
    localparam int BW       = $clog2(CHAIN_LEN),
    localparam int AW       = $clog2(DEPTH),
    localparam int IW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [IW-1:0] num_pat,
    output step_t         step,
    output logic [BW-1:0] bit_idx,
    output logic [AW-1:0] ld_addr,
    output logic [AW-1:0] ul_addr,
    output logic          start_acc,
    output logic          busy,
    output logic          done
);

    localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_LEN - 1);
    localparam logic [IW-1:0] MAX_PAT  = IW'(DEPTH);

    seq_state_e    state_q;
    test_mode_e    mode_q;
    logic [BW-1:0] bit_q;
    logic [IW-1:0] pat_q;
    logic [IW-1:0] npat_q;
    logic [IW-1:0] pat_nxt;
    logic [AW-1:0] unl_q;
    logic          load_q;
    logic          unload_q;
    logic          done_q;
    logic          last_bit;

    assign last_bit  = (bit_q == LAST_BIT);
    assign pat_nxt   = pat_q + 1'b1;
    assign start_acc = start && (state_q == ST_IDLE) && (num_pat != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_SA_OVL;
            bit_q    <= '0;
            pat_q    <= '0;
            npat_q   <= '0;
            unl_q    <= '0;
            load_q   <= 1'b0;
            unload_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_acc) begin
                        mode_q   <= test_mode_e'(mode);
                        npat_q   <= (num_pat > MAX_PAT) ? MAX_PAT : num_pat;
                        pat_q    <= '0;
                        bit_q    <= '0;
                        load_q   <= 1'b1;
                        unload_q <= 1'b0;
                        state_q  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        bit_q <= '0;
                        if (load_q) begin
                            state_q <= (mode_q == MODE_LOC) ? ST_LAUNCH : ST_CAPT;
                        end else if (pat_q == npat_q) begin
                            state_q  <= ST_IDLE;
                            unload_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            // serial mode: unload finished, start next load
                            load_q   <= 1'b1;
                            unload_q <= 1'b0;
                        end
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_LAUNCH: state_q <= ST_CAPT;
                ST_CAPT: begin
                    unl_q    <= pat_q[AW-1:0];
                    pat_q    <= pat_nxt;
                    unload_q <= 1'b1;
                    load_q   <= (pat_nxt != npat_q) && (mode_q != MODE_SA_SER);
                    state_q  <= ST_SHIFT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        step.shift     = (state_q == ST_SHIFT);
        step.load      = load_q && (state_q != ST_IDLE);
        step.unload    = unload_q && (state_q == ST_SHIFT);
        step.final_cap = (state_q == ST_CAPT);
        step.at_speed  = (((state_q == ST_LAUNCH) || (state_q == ST_CAPT)) && is_transition(mode_q))
                       || ((state_q == ST_SHIFT) && (mode_q == MODE_LOS) && load_q && last_bit);
    end

    assign bit_idx = LAST_BIT - bit_q;
    assign ld_addr = pat_q[AW-1:0];
    assign ul_addr = unl_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;

endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp #(
    parameter int PO_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            chk_chain,
    input  logic            exp_bit,
    input  logic            mask_bit,
    input  logic            scan_out,
    input  logic            chk_po,
    input  logic [PO_W-1:0] exp_po,
    input  logic [PO_W-1:0] po_in,
    output logic            fail
);

    logic miss_chain;
    logic miss_po;
    logic fail_q;

    assign miss_chain = chk_chain && !mask_bit && (scan_out != exp_bit);
    assign miss_po    = chk_po && (po_in != exp_po);

    always_ff @(posedge clk) begin
        if (rst || clear) fail_q <= 1'b0;
        else if (miss_chain || miss_po) fail_q <= 1'b1;
    end

    assign fail = fail_q;

endmodule

// File: rtl/scan_test_sequencer.sv
module scan_test_sequencer
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 6,
    parameter int PI_W      = 5,
    parameter int PO_W      = 3,
    parameter int DEPTH     = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int IW       = $clog2(DEPTH + 1),
    localparam int BW       = $clog2(CHAIN_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pat_we,
    input  logic [AW-1:0]        pat_addr,
    input  logic [CHAIN_LEN-1:0] pat_stim,
    input  logic [PI_W-1:0]      pat_pi,
    input  logic [CHAIN_LEN-1:0] pat_exp,
    input  logic [CHAIN_LEN-1:0] pat_mask,
    input  logic [PO_W-1:0]      pat_exp_po,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [IW-1:0]        num_pat,
    output logic                 scan_en,
    output logic                 scan_in,
    input  logic                 scan_out,
    output logic [PI_W-1:0]      pi_out,
    input  logic [PO_W-1:0]      po_in,
    output logic                 at_speed,
    output logic                 busy,
    output logic                 done,
    output logic                 fail
);

    step_t                step;
    logic [BW-1:0]        bit_idx;
    logic [AW-1:0]        ld_addr;
    logic [AW-1:0]        ul_addr;
    logic                 start_acc;
    logic [CHAIN_LEN-1:0] ld_stim;
    logic [PI_W-1:0]      ld_pi;
    logic [PO_W-1:0]      ld_exp_po;
    logic [CHAIN_LEN-1:0] ul_exp;
    logic [CHAIN_LEN-1:0] ul_mask;

    scan_seq_ctrl #(
        .CHAIN_LEN (CHAIN_LEN),
        .DEPTH     (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .num_pat   (num_pat),
        .step      (step),
        .bit_idx   (bit_idx),
        .ld_addr   (ld_addr),
        .ul_addr   (ul_addr),
        .start_acc (start_acc),
        .busy      (busy),
        .done      (done)
    );

    scan_pat_mem #(
        .CHAIN_LEN (CHAIN_LEN),
        .PI_W      (PI_W),
        .PO_W      (PO_W),
        .DEPTH     (DEPTH)
    ) u_mem (
        .clk       (clk),
        .we        (pat_we),
        .waddr     (pat_addr),
        .w_stim    (pat_stim),
        .w_pi      (pat_pi),
        .w_exp     (pat_exp),
        .w_mask    (pat_mask),
        .w_exp_po  (pat_exp_po),
        .ld_addr   (ld_addr),
        .ld_stim   (ld_stim),
        .ld_pi     (ld_pi),
        .ld_exp_po (ld_exp_po),
        .ul_addr   (ul_addr),
        .ul_exp    (ul_exp),
        .ul_mask   (ul_mask)
    );

    scan_resp_cmp #(
        .PO_W (PO_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_acc),
        .chk_chain (step.unload),
        .exp_bit   (ul_exp[bit_idx]),
        .mask_bit  (ul_mask[bit_idx]),
        .scan_out  (scan_out),
        .chk_po    (step.final_cap),
        .exp_po    (ld_exp_po),
        .po_in     (po_in),
        .fail      (fail)
    );

    assign scan_en  = step.shift;
    assign scan_in  = step.shift && step.load && ld_stim[bit_idx];
    assign pi_out   = step.load ? ld_pi : '0;
    assign at_speed = step.at_speed;

endmodule

// File: rtl/scan_test_sequencer_chk.sv
module scan_test_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic scan_en,
    input logic scan_in,
    input logic at_speed
);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_shift_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(scan_en)));

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (fail && !(start && !busy)) |=> fail);

    assert_speed_in_session_R7: assert property (@(posedge clk) disable iff (rst)
        at_speed |-> busy);

    assert_session_opens_shift_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (scan_en && $past(start)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scan_en && !scan_in));

endmodule

bind scan_test_sequencer scan_test_sequencer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .at_speed (at_speed)
);

// File: tb/test_scan_test_sequencer.sv
`timescale 1ns/1ps
module test_scan_test_sequencer;

    localparam int N  = 6;
    localparam int PI = 5;
    localparam int PO = 3;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pat_we = 1'b0;
    logic [1:0]    pat_addr = '0;
    logic [N-1:0]  pat_stim = '0;
    logic [PI-1:0] pat_pi = '0;
    logic [N-1:0]  pat_exp = '0;
    logic [N-1:0]  pat_mask = '0;
    logic [PO-1:0] pat_exp_po = '0;
    logic          start = 1'b0;
    logic [1:0]    mode = '0;
    logic [2:0]    num_pat = '0;
    logic          scan_en, scan_in, scan_out, at_speed, busy, done, fail;
    logic [PI-1:0] pi_out;
    logic [PO-1:0] po_in;

    always #2.5 clk = ~clk;

    scan_test_sequencer #(.CHAIN_LEN(N), .PI_W(PI), .PO_W(PO), .DEPTH(D)) i_scan_test_sequencer (
        .clk(clk), .rst(rst), .pat_we(pat_we), .pat_addr(pat_addr), .pat_stim(pat_stim),
        .pat_pi(pat_pi), .pat_exp(pat_exp), .pat_mask(pat_mask), .pat_exp_po(pat_exp_po),
        .start(start), .mode(mode), .num_pat(num_pat), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out), .pi_out(pi_out), .po_in(po_in), .at_speed(at_speed),
        .busy(busy), .done(done), .fail(fail)
    );

    // model of the block under test: next-state and primary-output functions
    function automatic logic [N-1:0] cut_next(logic [N-1:0] s, logic [PI-1:0] p);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = s[i] ^ s[(i + 1) % N] ^ p[i % PI];
        return r;
    endfunction

    function automatic logic [PO-1:0] cut_po(logic [N-1:0] s, logic [PI-1:0] p);
        logic [PO-1:0] r;
        for (int j = 0; j < PO; j++) r[j] = (s[j] & p[j]) ^ s[j + 3];
        return r;
    endfunction

    logic [N-1:0] chain = '0;
    always_ff @(posedge clk) begin
        if (scan_en) chain <= {chain[N-2:0], scan_in};
        else         chain <= cut_next(chain, pi_out);
    end
    assign scan_out = chain[N-1];
    assign po_in    = cut_po(chain, pi_out);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor
    bit           mon = 0;
    bit           prev_se = 0;
    int           cyc, se_lo, as_n, as_sh, dn, cap_n;
    logic [N-1:0]  tb_stim [D];
    logic [PI-1:0] tb_pi   [D];

    always @(negedge clk) begin
        if (mon) begin
            if (busy) cyc++;
            if (busy && !scan_en) se_lo++;
            if (at_speed) as_n++;
            if (at_speed && scan_en) as_sh++;
            if (done) dn++;
            if (busy && !scan_en && prev_se && cap_n < D) begin
                check(chain == tb_stim[cap_n], "R3 R13 chain at capture", int'(chain), int'(tb_stim[cap_n]));
                check(pi_out == tb_pi[cap_n], "R8 primary inputs", int'(pi_out), int'(tb_pi[cap_n]));
                cap_n++;
            end
            prev_se = scan_en;
        end
    end

    function automatic int exp_cycles(int md, int np);
        case (md)
            1: return np * (2 * N + 1);
            2: return np * (N + 2) + N;
            default: return np * (N + 1) + N;
        endcase
    endfunction

    // corrupt: 0 none, 1 flip unmasked chain bit, 2 flip primary-output bit
    task automatic run_case(input int md, input int np, input int seed, input int corrupt,
                            input bit restart, input int np_drive);
        string tag;
        int eff;
        eff = (np > D) ? D : np;
        tag = (md == 0) ? "R4" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R7";
        for (int p = 0; p < eff; p++) begin
            logic [N-1:0] st, rs, mk;
            logic [PI-1:0] pv;
            logic [PO-1:0] po;
            st = N'(p * 37 + seed * 11 + 9);
            pv = PI'(p * 13 + seed * 5 + 3);
            mk = N'(p * 9 + seed) & 6'b011011;
            if (md == 2) begin
                rs = cut_next(cut_next(st, pv), pv);
                po = cut_po(cut_next(st, pv), pv);
            end else begin
                rs = cut_next(st, pv);
                po = cut_po(st, pv);
            end
            rs = rs ^ mk;                         // masked bits deliberately wrong
            if (corrupt == 1 && p == 0) rs[5] = ~rs[5];
            if (corrupt == 2 && p == 0) po[0] = ~po[0];
            tb_stim[p] = st;
            tb_pi[p]   = pv;
            @(negedge clk);
            pat_we = 1'b1; pat_addr = 2'(p); pat_stim = st; pat_pi = pv;
            pat_exp = rs; pat_mask = mk; pat_exp_po = po;
        end
        @(negedge clk);
        pat_we = 1'b0;
        cyc = 0; se_lo = 0; as_n = 0; as_sh = 0; dn = 0; cap_n = 0; prev_se = 0;
        mon = 1;
        start = 1'b1; mode = 2'(md); num_pat = 3'(np_drive);
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            @(negedge clk);
            start = 1'b1; mode = 2'd1; num_pat = 3'd1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
        @(negedge clk);
        mon = 0;
        check(cyc == exp_cycles(md, eff), {tag, " busy cycles"}, cyc, exp_cycles(md, eff));
        check(se_lo == ((md == 2) ? 2 * eff : eff), {tag, " capture cycles"}, se_lo,
              (md == 2) ? 2 * eff : eff);
        check(as_n == ((md >= 2) ? 2 * eff : 0), {tag, " at-speed cycles"}, as_n,
              (md >= 2) ? 2 * eff : 0);
        check(as_sh == ((md == 3) ? eff : 0), "R7 at-speed shifts", as_sh, (md == 3) ? eff : 0);
        check(cap_n == eff, "R3 load count", cap_n, eff);
        check(dn == 1, "R12 done pulses", dn, 1);
        check(fail == (corrupt != 0), (corrupt == 2) ? "R11 po compare" :
              (corrupt == 1) ? "R9 chain mismatch" : "R10 masked compare", int'(fail), int'(corrupt != 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fail && !scan_en && !at_speed, "R1 reset state",
              int'({busy, done, fail, scan_en, at_speed}), 0);

        // R2: zero count is ignored
        start = 1'b1; num_pat = 3'd0; mode = 2'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !scan_en, "R2 zero count ignored", int'(busy), 0);

        // sweep all modes and counts
        for (int md = 0; md < 4; md++)
            for (int np = 1; np <= D; np++)
                run_case(md, np, md * 4 + np, 0, 0, np);

        run_case(0, 2, 21, 1, 0, 2);            // R9 unmasked mismatch
        check(fail, "R9 fail held while idle", int'(fail), 1);
        run_case(2, 3, 22, 0, 0, 3);            // clean run clears fail (R9)
        run_case(3, 2, 23, 2, 0, 2);            // R11
        run_case(1, 3, 24, 0, 0, 3);
        run_case(2, 3, 25, 0, 1, 3);            // R2 restart while busy ignored
        run_case(0, 5, 26, 0, 0, 5);            // R2 count above depth clamped

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule